// File: doc/BRIEF.md
# Two-wire bus slave address and byte engine

This block is the slave-side protocol engine for a two-wire serial bus. A separate condition monitor supplies filtered clock and data line levels together with one-cycle pulses marking START and STOP. After each START, the engine collects the address packet on rising clock edges. It compares the address with a programmable own address, and can also accept the all-zero general-call address. It then either acknowledges or stays silent on the ninth clock pulse.

Once addressed for a write, the engine collects data bytes and hands each one to a host over a valid/ready port. It acknowledges or refuses each byte according to a host-controlled level. Once addressed for a read, it asks the host for bytes over a second valid/ready port and shifts them onto the bus. Whenever the host has not yet completed a byte handshake, the engine holds the clock line low. Both bus lines are driven through active-high drive-low enables intended for open-drain pads.

Top module: `twi_slave_rx`

## Requirements
- R1: After START, eight bits are sampled on SCL rising edges, MSB first: seven address bits, then a direction bit where 1 means read. The internal bit counter never exceeds eight.
- R2: If the seven address bits equal `own_addr`, the slave drives SDA low (`sda_oe`=1) during the ninth SCL pulse. If they do not match, SDA stays released and the bus is ignored until the next START.
- R3: An `own_addr` of 0000000, or one whose upper four bits are 1111, never produces an own-address match.
- R4: Address 0000000 with the write bit is acknowledged only when `GCALL_SUPPORT`=1 and `gc_en`=1. Bytes that follow are delivered with `rx_gc`=1, while bytes received under an own-address match have `rx_gc`=0.
- R5: Address 0000000 with the read bit is never acknowledged.
- R6: As receiver, each data byte is taken MSB first. The byte is acknowledged if `rx_ack` is 1 at the eighth SCL falling edge and refused otherwise. A refused byte is still delivered to the host, and after it the slave ignores the bus until the next START.
- R7: `scl_oe` rises only after the SCL falling edge that ends a data acknowledge slot, or a read-address acknowledge slot. It stays high only while `rx_valid` or `tx_ready` is high, and it falls when the host handshake completes. A write-address acknowledge causes no stretch.
- R8: As transmitter, a byte from the host is driven MSB first. The first bit is driven when the byte is loaded, and each later bit is driven after an SCL falling edge. A master ACK leads to a request for the next byte. A master NACK ends the transfer with SDA released and `tx_ready` low.
- R9: `sda_oe` changes only after an SCL falling edge, during a stretch handshake, or on START or STOP. SDA is released on the falling edge that ends an acknowledge slot, so a following all-ones byte is received intact.
- R10: A START in any state releases both lines, drops a pending byte and restarts address collection. A STOP in any state releases both lines and returns to idle.
- R11: While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high and `rx_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | ADDR_W | Programmable slave address |
| gc_en | input | 1 | Accept general call (write) |
| scl_in | input | 1 | Filtered SCL line level |
| sda_in | input | 1 | Filtered SDA line level |
| start_det | input | 1 | One-cycle START/repeated START pulse |
| stop_det | input | 1 | One-cycle STOP pulse |
| scl_oe | output | 1 | Drive SCL low (clock stretch) |
| sda_oe | output | 1 | Drive SDA low |
| rx_data | output | DATA_W | Received byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Host takes received byte |
| rx_ack | input | 1 | 1 = acknowledge current byte, 0 = refuse |
| rx_gc | output | 1 | Current transfer was a general call |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | Host offers byte to send |
| tx_ready | output | 1 | Engine requests a byte to send |

## Verification
The hardest situations to reach are the mid-transfer ones. One is a repeated START that arrives after only some data bits of a byte. Another is a refused byte, after which the next byte must be ignored rather than acknowledged. Reaching them needs a bench-side bus master that can stop a byte partway. That master also has to wait whenever the slave holds SCL low. The bench host answers each handshake after a fixed latency, so every data byte produces a measurable stretch. Address behaviour is swept over all 128 addresses under a normal and a reserved own address.

// File: rtl/twi_slv_pkg.sv
package twi_slv_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_RX,
      ST_RACK,
      ST_RHOLD,
      ST_TLOAD,
      ST_TX,
      ST_TACK
   } slv_state_e;

   localparam int RSV_BITS = 4;
endpackage

// File: rtl/twi_scl_edge.sv
module twi_scl_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   output logic rise,
   output logic fall
);
   logic scl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_q <= 1'b1;
      else        scl_q <= scl_in;
   end

   assign rise = scl_in & ~scl_q;
   assign fall = ~scl_in & scl_q;
endmodule

// File: rtl/twi_shreg.sv
module twi_shreg #(
   parameter int W  = 8,
   parameter int CW = $clog2(W + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          samp,
   input  logic          bit_in,
   input  logic          cnt_only,
   input  logic          shl,
   input  logic          ld,
   input  logic [W-1:0]  ld_val,
   output logic [W-1:0]  sr,
   output logic [CW-1:0] cnt,
   output logic          full
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr  <= '0;
         cnt <= '0;
      end else if (ld) begin
         sr  <= ld_val;
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (samp) begin
         sr  <= {sr[W-2:0], bit_in};
         cnt <= cnt + 1'b1;
      end else if (shl) begin
         sr  <= {sr[W-2:0], 1'b1};
      end else if (cnt_only) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign full = (cnt == CW'(W));

   // R1
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(W));
endmodule

// File: rtl/twi_addr_cmp.sv
module twi_addr_cmp #(
   parameter int AW            = 7,
   parameter bit GCALL_SUPPORT = 1'b1
) (
   input  logic [AW-1:0] addr,
   input  logic          rw,
   input  logic [AW-1:0] own,
   input  logic          gc_en,
   output logic          own_hit,
   output logic          gc_hit
);
   import twi_slv_pkg::*;

   logic own_ok;
   assign own_ok  = (own != '0) && !(&own[AW-1 -: RSV_BITS]);
   assign own_hit = own_ok && (addr == own);

   generate
      if (GCALL_SUPPORT) begin : g_gc
         assign gc_hit = gc_en && (addr == '0) && !rw;
      end else begin : g_nogc
         logic unused_gc;
         assign unused_gc = gc_en ^ rw;
         assign gc_hit = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/twi_slave_rx.sv
module twi_slave_rx #(
   parameter int ADDR_W        = 7,
   parameter int DATA_W        = 8,
   parameter bit GCALL_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              gc_en,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic              start_det,
   input  logic              stop_det,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   input  logic              rx_ready,
   input  logic              rx_ack,
   output logic              rx_gc,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready
);
   import twi_slv_pkg::*;

   localparam int CW = $clog2(DATA_W + 1);

   generate
      if (ADDR_W < RSV_BITS + 1) begin : g_bad_aw
         $error("ADDR_W must exceed the reserved prefix width");
      end
      if (DATA_W != ADDR_W + 1) begin : g_bad_dw
         $error("DATA_W must equal ADDR_W + 1");
      end
   endgenerate

   slv_state_e        st;
   logic              rise, fall;
   logic [DATA_W-1:0] sr;
   logic [CW-1:0]     cnt;
   logic              full;
   logic              own_hit, gc_hit;
   logic              sda_q, rw_q, gc_q, nack_q, mack_q, rxv_q;
   logic [DATA_W-1:0] rxd_q;
   logic              clr, samp, cnt_only, shl, ld;
   logic              bus_evt;

   twi_scl_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_in (scl_in),
      .rise   (rise),
      .fall   (fall)
   );

   assign bus_evt  = start_det | stop_det;
   assign ld       = !bus_evt && (st == ST_TLOAD) && tx_valid;
   assign clr      = start_det
                   | ((st == ST_AACK) && fall)
                   | ((st == ST_RHOLD) && rx_ready);
   assign samp     = rise && !full && ((st == ST_ADDR) || (st == ST_RX));
   assign cnt_only = rise && !full && (st == ST_TX);
   assign shl      = fall && !full && (st == ST_TX) && (cnt != '0);

   twi_shreg #(.W(DATA_W), .CW(CW)) u_sr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .samp     (samp),
      .bit_in   (sda_in),
      .cnt_only (cnt_only),
      .shl      (shl),
      .ld       (ld),
      .ld_val   (tx_data),
      .sr       (sr),
      .cnt      (cnt),
      .full     (full)
   );

   twi_addr_cmp #(.AW(ADDR_W), .GCALL_SUPPORT(GCALL_SUPPORT)) u_cmp (
      .addr    (sr[DATA_W-1:1]),
      .rw      (sr[0]),
      .own     (own_addr),
      .gc_en   (gc_en),
      .own_hit (own_hit),
      .gc_hit  (gc_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         sda_q  <= 1'b0;
         rw_q   <= 1'b0;
         gc_q   <= 1'b0;
         nack_q <= 1'b0;
         mack_q <= 1'b0;
         rxv_q  <= 1'b0;
         rxd_q  <= '0;
      end else if (start_det) begin
         st    <= ST_ADDR;
         sda_q <= 1'b0;
         rxv_q <= 1'b0;
      end else if (stop_det) begin
         st    <= ST_IDLE;
         sda_q <= 1'b0;
         rxv_q <= 1'b0;
      end else begin
         case (st)
            ST_ADDR: if (fall && full) begin
               if (own_hit || gc_hit) begin
                  st    <= ST_AACK;
                  sda_q <= 1'b1;
                  rw_q  <= sr[0];
                  gc_q  <= gc_hit;
               end else begin
                  st <= ST_IDLE;
               end
            end
            ST_AACK: if (fall) begin
               sda_q <= 1'b0;
               st    <= rw_q ? ST_TLOAD : ST_RX;
            end
            ST_RX: if (fall && full) begin
               sda_q  <= rx_ack;
               nack_q <= !rx_ack;
               rxd_q  <= sr;
               st     <= ST_RACK;
            end
            ST_RACK: if (fall) begin
               sda_q <= 1'b0;
               rxv_q <= 1'b1;
               st    <= ST_RHOLD;
            end
            ST_RHOLD: if (rx_ready) begin
               rxv_q <= 1'b0;
               st    <= nack_q ? ST_IDLE : ST_RX;
            end
            ST_TLOAD: if (tx_valid) begin
               sda_q <= !tx_data[DATA_W-1];
               st    <= ST_TX;
            end
            ST_TX: begin
               if (fall && full) begin
                  sda_q <= 1'b0;
                  st    <= ST_TACK;
               end else if (fall && (cnt != '0)) begin
                  sda_q <= !sr[DATA_W-2];
               end
            end
            ST_TACK: begin
               if (rise) mack_q <= !sda_in;
               if (fall) st <= mack_q ? ST_TLOAD : ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign sda_oe   = sda_q;
   assign scl_oe   = (st == ST_RHOLD) || (st == ST_TLOAD);
   assign tx_ready = (st == ST_TLOAD);
   assign rx_valid = rxv_q;
   assign rx_data  = rxd_q;
   assign rx_gc    = gc_q;

   // R7
   stretch_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_oe) |-> $past(fall));

   // R7
   stretch_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scl_oe |-> (rx_valid || tx_ready));

   // R9
   sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> $past(fall || scl_oe || start_det || stop_det));

   // R3
   rsv_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_AACK) && sda_oe) |-> !(&sr[DATA_W-1 -: RSV_BITS]));

   // R5
   gc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_AACK) && sda_oe) |-> !((sr[DATA_W-1:1] == '0) && sr[0]));

   // R11
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready && !start_det && !stop_det)
         |=> (rx_valid && $stable(rx_data)));

   // R7
   port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_valid, tx_ready}));
endmodule

// File: tb/sim_twi_slave_rx.sv
module sim_twi_slave_rx;
   localparam int HP  = 4;
   localparam int LAT = 12;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n;
   logic [6:0] own;
   logic       gc_en;
   logic       m_scl, m_sda;
   logic       start_det, stop_det;
   logic       rx_ack;
   logic       rx_ready;
   logic [7:0] tx_data;
   logic       tx_valid;
   wire        scl_oe, sda_oe, rx_valid, rx_gc, tx_ready;
   wire [7:0]  rx_data;
   wire        scl_in = m_scl & ~scl_oe;
   wire        sda_in = m_sda & ~sda_oe;

   int tests = 0, fails = 0;
   int rx_cnt, tx_idx, hcnt, tcnt, stretch;
   logic [7:0] rx_buf [0:15];
   logic       rx_gcb [0:15];
   logic [7:0] tx_buf [0:3];
   bit done = 0;

   twi_slave_rx u0 (
      .clk(clk), .rst_n(rst_n), .own_addr(own), .gc_en(gc_en),
      .scl_in(scl_in), .sda_in(sda_in), .start_det(start_det), .stop_det(stop_det),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_data(rx_data), .rx_valid(rx_valid),
      .rx_ready(rx_ready), .rx_ack(rx_ack), .rx_gc(rx_gc), .tx_data(tx_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready)
   );

   // bench host: answers each handshake after LAT cycles
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_ready <= 0; tx_valid <= 0; tx_data <= 0;
         rx_cnt <= 0; tx_idx <= 0; hcnt <= 0; tcnt <= 0; stretch <= 0;
      end else begin
         if (scl_oe) stretch <= stretch + 1;
         if (rx_ready) begin
            rx_ready <= 0; hcnt <= 0;
         end else if (rx_valid) begin
            if (hcnt == LAT) begin
               rx_ready <= 1;
               rx_buf[rx_cnt[3:0]] <= rx_data;
               rx_gcb[rx_cnt[3:0]] <= rx_gc;
               rx_cnt <= rx_cnt + 1;
            end else hcnt <= hcnt + 1;
         end else hcnt <= 0;
         if (tx_valid) begin
            tx_valid <= 0; tcnt <= 0;
         end else if (tx_ready) begin
            if (tcnt == LAT) begin
               tx_valid <= 1;
               tx_data  <= tx_buf[tx_idx[1:0]];
               tx_idx   <= tx_idx + 1;
            end else tcnt <= tcnt + 1;
         end else tcnt <= 0;
      end
   end

   task automatic hw(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic scl_high();
      m_scl = 1;
      @(negedge clk);
      while (!scl_in) @(negedge clk);
   endtask

   task automatic bus_bit(input logic b, output logic r);
      m_sda = b; hw(HP);
      scl_high(); hw(HP);
      r = sda_in;
      m_scl = 0; hw(HP);
   endtask

   task automatic do_start();
      m_sda = 0; start_det = 1;
      @(negedge clk); start_det = 0;
      hw(HP); m_scl = 0; hw(HP);
   endtask

   task automatic do_rstart();
      m_sda = 1; hw(HP);
      scl_high(); hw(HP);
      do_start();
   endtask

   task automatic do_stop();
      m_sda = 0; hw(HP);
      scl_high(); hw(HP);
      m_sda = 1; stop_det = 1;
      @(negedge clk); stop_det = 0;
      hw(HP);
   endtask

   task automatic wr_byte(input logic [7:0] v, output logic acked);
      logic r;
      for (int i = 7; i >= 0; i--) bus_bit(v[i], r);
      bus_bit(1'b1, r);
      acked = !r;
   endtask

   task automatic rd_byte(input logic give_ack, output logic [7:0] v);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         bus_bit(1'b1, r);
         v[i] = r;
      end
      bus_bit(!give_ack, r);
   endtask

   task automatic probe(input logic [6:0] a, input logic rw, output logic acked);
      logic [7:0] v;
      do_start();
      wr_byte({a, rw}, acked);
      if (acked && rw) rd_byte(1'b0, v);
      do_stop();
   endtask

   function automatic logic exp_ack(input logic [6:0] a, input logic rw,
                                    input logic [6:0] o, input logic g);
      logic own_ok;
      own_ok = (o != 0) && (o[6:3] != 4'hF);
      return (own_ok && a == o) || (g && a == 0 && !rw);
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic ack;
      logic [7:0] v;
      int base, s0;
      rst_n = 0; own = 7'h2A; gc_en = 1; m_scl = 1; m_sda = 1;
      start_det = 0; stop_det = 0; rx_ack = 1;
      tx_buf[0] = 8'h96; tx_buf[1] = 8'h5A; tx_buf[2] = 8'hC3; tx_buf[3] = 8'h01;
      hw(5);
      chk(scl_oe == 0, "R7 reset scl_oe", scl_oe, 0);
      chk(sda_oe == 0, "R9 reset sda_oe", sda_oe, 0);
      chk(rx_valid == 0 && tx_ready == 0, "R10 reset ports", {rx_valid, tx_ready}, 0);
      rst_n = 1; hw(5);

      // address sweep, normal own address, general call on
      for (int a = 0; a < 128; a++) begin
         probe(a[6:0], 1'b0, ack);
         chk(ack == exp_ack(a[6:0], 0, own, gc_en), a == 0 ? "R4 gc write" : "R2 sweep",
             ack, exp_ack(a[6:0], 0, own, gc_en));
      end
      probe(7'h2A, 1'b1, ack); chk(ack == 1, "R1 own read", ack, 1);
      probe(7'h00, 1'b1, ack); chk(ack == 0, "R5 gc read", ack, 0);

      // reserved own address, general call off
      own = 7'h7B; gc_en = 0;
      for (int a = 0; a < 128; a++) begin
         probe(a[6:0], 1'b0, ack);
         chk(ack == 0, "R3 reserved own", ack, 0);
      end
      own = 7'h78; probe(7'h78, 1'b1, ack); chk(ack == 0, "R3 reserved read", ack, 0);
      own = 7'h00; probe(7'h00, 1'b0, ack); chk(ack == 0, "R3 zero own", ack, 0);
      own = 7'h2A; gc_en = 1;

      // receive with stretching
      base = rx_cnt; s0 = stretch;
      do_start();
      wr_byte(8'h54, ack); chk(ack == 1, "R2 write ack", ack, 1);
      chk(stretch == s0, "R7 no stretch on write address", stretch - s0, 0);
      wr_byte(8'hA5, ack); chk(ack == 1, "R6 byte ack", ack, 1);
      wr_byte(8'hFF, ack); chk(ack == 1, "R9 ones byte ack", ack, 1);
      do_stop(); hw(5);
      chk(rx_cnt == base + 2, "R6 byte count", rx_cnt - base, 2);
      chk(rx_buf[base[3:0]] == 8'hA5, "R11 byte0", rx_buf[base[3:0]], 8'hA5);
      chk(rx_buf[base[3:0] + 4'd1] == 8'hFF, "R9 byte1", rx_buf[base[3:0] + 4'd1], 8'hFF);
      chk(stretch - s0 >= 2 * LAT, "R7 stretch length", stretch - s0, 2 * LAT);
      chk(rx_gcb[base[3:0]] == 0, "R4 own gc flag", rx_gcb[base[3:0]], 0);

      // refused byte, then ignored byte
      base = rx_cnt;
      do_start();
      wr_byte(8'h54, ack);
      rx_ack = 0;
      wr_byte(8'h81, ack); chk(ack == 0, "R6 refused", ack, 0);
      rx_ack = 1;
      wr_byte(8'h42, ack); chk(ack == 0, "R6 ignored after refuse", ack, 0);
      do_stop(); hw(5);
      chk(rx_cnt == base + 1, "R6 refused delivered", rx_cnt - base, 1);
      chk(rx_buf[base[3:0]] == 8'h81, "R6 refused value", rx_buf[base[3:0]], 8'h81);

      // general call write
      base = rx_cnt;
      do_start();
      wr_byte(8'h00, ack); chk(ack == 1, "R4 gc ack", ack, 1);
      wr_byte(8'h77, ack); chk(ack == 1, "R4 gc byte ack", ack, 1);
      do_stop(); hw(5);
      chk(rx_buf[base[3:0]] == 8'h77, "R4 gc value", rx_buf[base[3:0]], 8'h77);
      chk(rx_gcb[base[3:0]] == 1, "R4 gc flag", rx_gcb[base[3:0]], 1);

      // transmit
      base = tx_idx;
      do_start();
      wr_byte(8'h55, ack); chk(ack == 1, "R8 read addr ack", ack, 1);
      rd_byte(1'b1, v);
      chk(v == tx_buf[base[1:0]], "R8 tx byte0", v, tx_buf[base[1:0]]);
      rd_byte(1'b0, v);
      chk(v == tx_buf[base[1:0] + 2'd1], "R8 tx byte1", v, tx_buf[base[1:0] + 2'd1]);
      hw(3);
      chk(tx_ready == 0, "R8 no request after nack", tx_ready, 0);
      chk(sda_oe == 0, "R8 sda released", sda_oe, 0);
      chk(scl_oe == 0, "R7 no stretch after nack", scl_oe, 0);
      do_stop();

      // repeated start partway through a byte
      base = rx_cnt;
      do_start();
      wr_byte(8'h54, ack);
      bus_bit(1, ack); bus_bit(0, ack); bus_bit(1, ack); bus_bit(0, ack);
      do_rstart();
      wr_byte(8'h54, ack); chk(ack == 1, "R10 rstart addr ack", ack, 1);
      wr_byte(8'h0F, ack); chk(ack == 1, "R10 rstart byte ack", ack, 1);
      do_stop(); hw(5);
      chk(rx_cnt == base + 1, "R10 rstart count", rx_cnt - base, 1);
      chk(rx_buf[base[3:0]] == 8'h0F, "R10 rstart value", rx_buf[base[3:0]], 8'h0F);

      // stop partway through a byte
      do_start();
      wr_byte(8'h54, ack);
      bus_bit(0, ack); bus_bit(0, ack); bus_bit(1, ack);
      do_stop(); hw(2);
      chk(sda_oe == 0 && scl_oe == 0, "R10 stop releases", {sda_oe, scl_oe}, 0);
      chk(rx_valid == 0, "R10 stop no byte", rx_valid, 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule